// File: doc/BRIEF.md
# Configurable Output Logic Cell

This block is a single output cell of a small programmable logic device. It receives a fixed set of product terms that an AND array upstream has already evaluated. It gates each term through a per-term enable mask and sums the survivors in a fixed OR. The sum can optionally be inverted. It then reaches the pin either straight through or through a register clocked by the single global clock.

A separate output-enable product term gates the pin driver. When the driver is off, the pin floats and other cells may drive a shared line. A two-bit mode code chooses between combinational, registered and input-only operation. In input-only operation the driver is released and the pin value is returned to the array as an ordinary input.

The pin is split into a drive value (`pad_o`), a drive enable (`pad_oe`) and the observed pin level (`pad_i`), so the surrounding pad ring resolves the tri-state. All configuration inputs are static settings. The power-up clear of the register is modelled as a synchronous active-high reset.

Top module: `pld_out_cell`

## Requirements
- R1: The sum is the OR of `pterm[i] & term_en[i]` over all terms; a term whose enable bit is 0 contributes 0, and with all enables 0 the sum is 0.
- R2: With `cfg_invert` = 1 the sum is inverted before the output stage; with 0 it passes unchanged.
- R3: In combinational mode (`cfg_mode` = 2'b00) with the driver enabled, `pad_o` equals the polarity-stage output in the same cycle, without waiting for a clock edge.
- R4: In registered mode (`cfg_mode` = 2'b01) the register loads the polarity-stage output on each rising clock edge, and with the driver enabled `pad_o` shows the register.
- R5: While `rst` is 1 at a rising edge, the register is cleared to 0. In registered mode `pad_o` is then 0 even with `cfg_invert` = 1 and every term true.
- R6: In combinational or registered mode, `pad_oe` equals `oe_term`; whenever `pad_oe` is 0, `pad_o` is held at 0.
- R7: In input-only mode (`cfg_mode` = 2'b10) and for the unused code 2'b11, `pad_oe` is 0 regardless of `oe_term`.
- R8: The feedback output `fb` is the register in registered mode and the pin level `pad_i` in every other mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Global clock; the register loads on its rising edge |
| rst | input | 1 | Synchronous active-high clear of the register (power-up model) |
| cfg_mode | input | 2 | 00 combinational, 01 registered, 10 input-only, 11 treated as input-only |
| cfg_invert | input | 1 | 1 inverts the OR sum before the output stage |
| term_en | input | NTERM | Per-term enable mask for the OR |
| pterm | input | NTERM | Product-term values from the AND array |
| oe_term | input | 1 | Output-enable product term |
| pad_i | input | 1 | Level observed on the pin |
| pad_o | output | 1 | Value driven onto the pin (0 when not driving) |
| pad_oe | output | 1 | Pin driver enable; 0 means high impedance |
| fb | output | 1 | Feedback signal returned to the AND array |

## Verification
The bench builds the cell with the default of eight product terms. At that width, every mask pattern in the stimulus table can be written out by hand: the empty mask, a single low or high term, and alternating patterns whose enabled and true terms never overlap. The bench wires `pad_i` to the driven value when `pad_oe` is 1 and to an external level otherwise. This lets the feedback path be seen both as a loop-back of the cell's own drive and as a true external input. A cycle-accurate model of the register in the bench makes changes between modes and reset pulses in the middle of a run visible at the pin.

// File: rtl/pld_cell_pkg.sv
package pld_cell_pkg;

    typedef enum logic [1:0] {
        MODE_COMB  = 2'b00,
        MODE_REG   = 2'b01,
        MODE_INPUT = 2'b10,
        MODE_SPARE = 2'b11
    } cell_mode_e;

    function automatic logic mode_drives(cell_mode_e m);
        return (m == MODE_COMB) || (m == MODE_REG);
    endfunction

endpackage

// File: rtl/pld_term_sum.sv
module pld_term_sum #(
    parameter int NTERM = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NTERM-1:0] pterm,
    input  logic [NTERM-1:0] term_en,
    input  logic             invert,
    output logic             sum,
    output logic             pol
);
    logic [NTERM-1:0] gated;

    for (genvar g = 0; g < NTERM; g++) begin : g_gate
        assign gated[g] = pterm[g] & term_en[g];
    end

    assign sum = |gated;
    assign pol = sum ^ invert;

    // R1: an empty mask leaves nothing in the OR
    assert_empty_mask_R1: assert property (@(posedge clk) disable iff (rst)
        (term_en == '0) |-> !sum);

    // R2: the polarity stage keeps the sum or flips it, as the select asks
    assert_polarity_R2: assert property (@(posedge clk) disable iff (rst)
        invert |-> (pol != sum));
endmodule

// File: rtl/pld_out_reg.sv
module pld_out_reg (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= d;
    end

    // R5: a reset edge leaves the register at 0
    assert_reset_clear_R5: assert property (@(posedge clk)
        rst |=> !q);
endmodule

// File: rtl/pld_pin_ctrl.sv
module pld_pin_ctrl
    import pld_cell_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  cell_mode_e mode,
    input  logic       pol,
    input  logic       reg_q,
    input  logic       oe_term,
    input  logic       pad_i,
    output logic       pad_o,
    output logic       pad_oe,
    output logic       fb
);
    logic drive_val;

    always_comb begin
        drive_val = 1'b0;
        fb        = pad_i;
        unique case (mode)
            MODE_COMB:  begin drive_val = pol;   fb = pad_i; end
            MODE_REG:   begin drive_val = reg_q; fb = reg_q; end
            MODE_INPUT: begin drive_val = 1'b0;  fb = pad_i; end
            MODE_SPARE: begin drive_val = 1'b0;  fb = pad_i; end
        endcase
    end

    assign pad_oe = mode_drives(mode) & oe_term;
    assign pad_o  = pad_oe & drive_val;

    // R7: input-only codes never turn the driver on
    assert_input_undriven_R7: assert property (@(posedge clk) disable iff (rst)
        mode[1] |-> !pad_oe);

    // R6: a released pin carries no value
    assert_idle_low_R6: assert property (@(posedge clk) disable iff (rst)
        !pad_oe |-> !pad_o);

    // R8: in registered mode the feedback agrees with what is driven
    assert_fb_matches_drive_R8: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_REG && pad_oe) |-> (fb == pad_o));
endmodule

// File: rtl/pld_out_cell.sv
module pld_out_cell
    import pld_cell_pkg::*;
#(
    parameter int NTERM = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       cfg_mode,
    input  logic             cfg_invert,
    input  logic [NTERM-1:0] term_en,
    input  logic [NTERM-1:0] pterm,
    input  logic             oe_term,
    input  logic             pad_i,
    output logic             pad_o,
    output logic             pad_oe,
    output logic             fb
);
    cell_mode_e mode;
    logic       sum_w;
    logic       pol_w;
    logic       reg_q;

    assign mode = cell_mode_e'(cfg_mode);

    pld_term_sum #(.NTERM(NTERM)) u_sum (
        .clk     (clk),
        .rst     (rst),
        .pterm   (pterm),
        .term_en (term_en),
        .invert  (cfg_invert),
        .sum     (sum_w),
        .pol     (pol_w)
    );

    pld_out_reg u_reg (
        .clk (clk),
        .rst (rst),
        .d   (pol_w),
        .q   (reg_q)
    );

    pld_pin_ctrl u_pin (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode),
        .pol     (pol_w),
        .reg_q   (reg_q),
        .oe_term (oe_term),
        .pad_i   (pad_i),
        .pad_o   (pad_o),
        .pad_oe  (pad_oe),
        .fb      (fb)
    );

    // R4: a driven pin in registered mode shows the value sampled one edge earlier
    assert_reg_capture_R4: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_REG && oe_term && !$past(rst)) |-> (pad_o == $past(pol_w)));

    // R3: a driven pin in combinational mode follows the polarity stage at once
    assert_comb_follow_R3: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_COMB && oe_term) |-> (pad_o == pol_w));
endmodule

// File: tb/pld_out_cell_tb_top.sv
module pld_out_cell_tb_top;
    logic       clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst = 1'b1;
    logic [1:0] mode = 2'b00;
    logic       inv = 1'b0, oe = 1'b0, ext = 1'b0;
    logic [7:0] en = 8'h00, pt = 8'h00;
    logic       pad_i, pad_o, pad_oe, fb;
    logic       q_exp = 1'b0;
    int         total = 0, bad = 0;
    bit         done = 0;

    assign pad_i = pad_oe ? pad_o : ext;

    pld_out_cell #(.NTERM(8)) dut_i (
        .clk(clk), .rst(rst), .cfg_mode(mode), .cfg_invert(inv),
        .term_en(en), .pterm(pt), .oe_term(oe), .pad_i(pad_i),
        .pad_o(pad_o), .pad_oe(pad_oe), .fb(fb)
    );

    // fields: mode[20:19] inv[18] oe[17] en[16:9] pt[8:1] ext[0]
    localparam logic [20:0] VEC [16] = '{
        {2'b00, 1'b0, 1'b1, 8'h01, 8'h01, 1'b0},
        {2'b00, 1'b0, 1'b1, 8'h0F, 8'h10, 1'b1},
        {2'b00, 1'b1, 1'b1, 8'hFF, 8'h00, 1'b0},
        {2'b00, 1'b1, 1'b0, 8'hFF, 8'h80, 1'b1},
        {2'b01, 1'b0, 1'b1, 8'hFF, 8'h80, 1'b0},
        {2'b01, 1'b0, 1'b1, 8'hFF, 8'h00, 1'b1},
        {2'b01, 1'b1, 1'b1, 8'h0F, 8'h0F, 1'b0},
        {2'b01, 1'b1, 1'b0, 8'hF0, 8'h00, 1'b0},
        {2'b01, 1'b1, 1'b1, 8'hF0, 8'h00, 1'b1},
        {2'b10, 1'b0, 1'b1, 8'hFF, 8'hFF, 1'b1},
        {2'b10, 1'b1, 1'b1, 8'hFF, 8'h00, 1'b0},
        {2'b11, 1'b0, 1'b1, 8'h01, 8'h01, 1'b1},
        {2'b11, 1'b1, 1'b0, 8'h00, 8'h00, 1'b0},
        {2'b00, 1'b0, 1'b1, 8'h80, 8'h7F, 1'b1},
        {2'b01, 1'b0, 1'b1, 8'h80, 8'h80, 1'b0},
        {2'b00, 1'b1, 1'b1, 8'h55, 8'hAA, 1'b0}
    };

    task automatic chk(string tag, string what, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    task automatic step(logic r, logic [1:0] m, logic i, logic o,
                        logic [7:0] e, logic [7:0] p, logic x, string tag_o);
        logic pol, eoe, eo, efb;
        @(negedge clk);
        rst = r; mode = m; inv = i; oe = o; en = e; pt = p; ext = x;
        @(posedge clk);
        pol   = (|(p & e)) ^ i;
        q_exp = r ? 1'b0 : pol;
        #1;
        eoe = ((m == 2'b00) || (m == 2'b01)) && o;
        eo  = eoe ? ((m == 2'b01) ? q_exp : pol) : 1'b0;
        efb = (m == 2'b01) ? q_exp : (eoe ? eo : x);
        chk(tag_o, "pad_o", pad_o, eo);
        chk(m[1] ? "R7" : "R6", "pad_oe", pad_oe, eoe);
        chk("R8", "fb", fb, efb);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            bad++; total++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // reset state, registered mode with everything true and inverted
        step(1'b1, 2'b01, 1'b0, 1'b1, 8'hFF, 8'hFF, 1'b0, "R5");
        step(1'b1, 2'b01, 1'b1, 1'b1, 8'hFF, 8'hFF, 1'b0, "R5");

        for (int k = 0; k < 16; k++) begin
            logic [20:0] v;
            string t;
            v = VEC[k];
            t = (v[20:19] == 2'b01) ? "R4" : (!v[17] ? "R6" : "R3");
            step(1'b0, v[20:19], v[18], v[17], v[16:9], v[8:1], v[0], t);
        end

        // R1: masked terms give 0; top term alone gives 1
        step(1'b0, 2'b00, 1'b0, 1'b1, 8'h00, 8'hFF, 1'b1, "R1");
        step(1'b0, 2'b00, 1'b0, 1'b1, 8'h80, 8'h80, 1'b0, "R1");
        // R2: empty sum inverted, in both output paths
        step(1'b0, 2'b00, 1'b1, 1'b1, 8'h00, 8'hFF, 1'b0, "R2");
        step(1'b0, 2'b01, 1'b1, 1'b1, 8'h00, 8'hFF, 1'b0, "R2");
        // R5: reset in the middle of a registered run
        step(1'b1, 2'b01, 1'b1, 1'b1, 8'hFF, 8'h00, 1'b0, "R5");
        step(1'b0, 2'b01, 1'b0, 1'b1, 8'hFF, 8'h01, 1'b0, "R4");
        // R7: spare code with the enable term true
        step(1'b0, 2'b11, 1'b1, 1'b1, 8'hFF, 8'hFF, 1'b1, "R7");

        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule